// File: doc/BRIEF.md
# Execute-Mode Strobe Remapper with Sequential Code Fetch

This block sits between a processor's active-low memory strobes and two targets: the chip enable of an external flash device and the read port of an on-chip byte buffer. In normal mode it passes the code-select strobe straight through to the flash chip enable. Data reads and writes go to the internal register decode and never select the flash.

In execute mode the roles swap. Every code fetch is served from the buffer as a sequential byte stream, and the processor address plays no part. Every data write drives the flash chip enable, so a program running from the buffer can erase and reprogram the flash. The internal register decode is shut off so that no on-chip register answers a write meant for the flash.

The stream has a latency of one fetch. A fetch returns the holding register. When the strobe ends, the holding register is reloaded from the buffer at the current read address, and the address then steps by one. A clear pulse zeroes both the holding register and the address. The first fetch after a clear therefore yields 0x00, and the fetches after it yield buffer locations 0, 1, 2 and so on.

The fetch path has no valid/ready pair. The processor's strobe paces every transfer and cannot be stalled, so there is no back-pressure. A byte is presented for exactly as long as the strobe is held.

Top module: `exec_strobe_remap`

## Requirements
- R1: With exec_en low, flash_ce_n equals code_sel_n combinationally.
- R2: With exec_en low, a low wr_n while code_sel_n is high leaves flash_ce_n high.
- R3: With exec_en high, flash_ce_n equals wr_n, so any write selects the flash whatever the address.
- R4: With exec_en high, a low code_sel_n with wr_n high leaves flash_ce_n high.
- R5: buf_raddr changes only by stepping +1 or by a clear. In execute mode it steps exactly once per completed code-select strobe, no later than SYNC_STAGES+2 clocks after code_sel_n rises. Strobes completed in normal mode do not move it.
- R6: With exec_en high, reg_rd_n and reg_wr_n are held high and regmap_dis is high. With exec_en low, reg_rd_n follows rd_n, reg_wr_n follows wr_n, and regmap_dis is low.
- R7: A fetch presents the holding register on fetch_data. At the end of an execute-mode strobe, the holding register is loaded with buf_rdata read at the pre-step buf_raddr.
- R8: One clock after clear is high, fetch_data is 0x00 and buf_raddr is 0. Clear wins over a step in the same cycle.
- R9: The read address wraps from BUF_DEPTH-1 (2047 by default) to 0.
- R10: fetch_oe is high exactly when exec_en is high and code_sel_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_sel_n | input | 1 | Active-low code fetch strobe from the processor |
| rd_n | input | 1 | Active-low data read strobe |
| wr_n | input | 1 | Active-low data write strobe |
| exec_en | input | 1 | Execute-mode flag |
| clear | input | 1 | Zeroes holding register and read address |
| buf_rdata | input | DATA_W | Byte read from the buffer at buf_raddr |
| flash_ce_n | output | 1 | Active-low flash chip enable |
| buf_raddr | output | ADDR_W | Buffer read address |
| fetch_data | output | DATA_W | Fetched instruction byte |
| fetch_oe | output | 1 | Drive enable for fetch_data onto the data bus |
| reg_rd_n | output | 1 | Read strobe forwarded to the internal register decode |
| reg_wr_n | output | 1 | Write strobe forwarded to the internal register decode |
| regmap_dis | output | 1 | High while the internal register map is disabled |

## Verification
The bench targets these faults:
- An off-by-one in the latency. A design that returns the current location instead of the held byte gives buffer[0] on the first fetch after clear instead of 0x00.
- The wrap at the last location. The bench runs more than 2048 fetches, so a counter that saturates or spills shows up as a repeated or wrong byte.
- Steps in the wrong mode. A remapper that also steps on normal-mode strobes breaks the stream after a mode round trip.
- Flash selects in the wrong mode. Random writes and fetches in both modes catch a design that selects the flash on a normal write or on an execute fetch.

// File: rtl/exec_remap_pkg.sv
package exec_remap_pkg;
  localparam int unsigned DEF_DATA_W      = 8;
  localparam int unsigned DEF_BUF_DEPTH   = 2048;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_EXEC   = 1'b1
  } remap_mode_e;

  typedef struct packed {
    logic flash_ce_n;
    logic reg_rd_n;
    logic reg_wr_n;
    logic regmap_dis;
    logic fetch_oe;
  } route_out_t;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n,
  output logic rise
);
  localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] chain;
  logic         prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[N-2:0], async_n};
      prev  <= chain[N-1];
    end
  end

  assign rise = chain[N-1] & ~prev;
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned BUF_DEPTH = 2048,
  parameter int unsigned ADDR_W    = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] hold
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(BUF_DEPTH - 1);

  logic [ADDR_W-1:0] addr_nxt;

  always_comb begin
    if (addr == LAST) addr_nxt = '0;
    else              addr_nxt = addr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      hold <= '0;
    end else if (clear) begin
      addr <= '0;
      hold <= '0;
    end else if (step) begin
      hold <= rdata;
      addr <= addr_nxt;
    end
  end
endmodule

// File: rtl/strobe_route.sv
module strobe_route
  import exec_remap_pkg::*;
(
  input  logic       exec_en,
  input  logic       code_sel_n,
  input  logic       rd_n,
  input  logic       wr_n,
  output route_out_t route
);
  remap_mode_e mode;

  assign mode = exec_en ? MODE_EXEC : MODE_NORMAL;

  always_comb begin
    unique case (mode)
      MODE_EXEC: begin
        route.flash_ce_n = wr_n;
        route.reg_rd_n   = 1'b1;
        route.reg_wr_n   = 1'b1;
        route.regmap_dis = 1'b1;
        route.fetch_oe   = ~code_sel_n;
      end
      default: begin
        route.flash_ce_n = code_sel_n;
        route.reg_rd_n   = rd_n;
        route.reg_wr_n   = wr_n;
        route.regmap_dis = 1'b0;
        route.fetch_oe   = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/exec_strobe_remap.sv
module exec_strobe_remap
  import exec_remap_pkg::*;
#(
  parameter int unsigned DATA_W      = DEF_DATA_W,
  parameter int unsigned BUF_DEPTH   = DEF_BUF_DEPTH,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  localparam int unsigned ADDR_W     = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_sel_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              exec_en,
  input  logic              clear,
  input  logic [DATA_W-1:0] buf_rdata,
  output logic              flash_ce_n,
  output logic [ADDR_W-1:0] buf_raddr,
  output logic [DATA_W-1:0] fetch_data,
  output logic              fetch_oe,
  output logic              reg_rd_n,
  output logic              reg_wr_n,
  output logic              regmap_dis
);
  logic       fetch_done;
  logic       step;
  route_out_t route;

  strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_n (code_sel_n),
    .rise    (fetch_done)
  );

  // A completed strobe only advances the stream in execute mode
  assign step = fetch_done & exec_en;

  fetch_seq #(
    .DATA_W    (DATA_W),
    .BUF_DEPTH (BUF_DEPTH),
    .ADDR_W    (ADDR_W)
  ) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .step  (step),
    .rdata (buf_rdata),
    .addr  (buf_raddr),
    .hold  (fetch_data)
  );

  strobe_route u_route (
    .exec_en    (exec_en),
    .code_sel_n (code_sel_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .route      (route)
  );

  assign flash_ce_n = route.flash_ce_n;
  assign reg_rd_n   = route.reg_rd_n;
  assign reg_wr_n   = route.reg_wr_n;
  assign regmap_dis = route.regmap_dis;
  assign fetch_oe   = route.fetch_oe;
endmodule

// File: rtl/exec_remap_checker.sv
module exec_remap_checker #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned BUF_DEPTH = 2048,
  parameter int unsigned ADDR_W    = $clog2(BUF_DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              code_sel_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              exec_en,
  input logic              clear,
  input logic [DATA_W-1:0] buf_rdata,
  input logic              flash_ce_n,
  input logic [ADDR_W-1:0] buf_raddr,
  input logic [DATA_W-1:0] fetch_data,
  input logic              fetch_oe,
  input logic              reg_rd_n,
  input logic              reg_wr_n,
  input logic              regmap_dis
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(BUF_DEPTH - 1);

  assert_ce_follows_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |-> flash_ce_n == code_sel_n);

  assert_no_ce_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_en && code_sel_n && !wr_n) |-> flash_ce_n);

  assert_write_selects_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && !wr_n) |-> !flash_ce_n);

  assert_fetch_no_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && wr_n) |-> flash_ce_n);

  assert_addr_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(buf_raddr) && !$past(clear)) |->
      buf_raddr == (($past(buf_raddr) == LAST) ? '0 : $past(buf_raddr) + 1'b1));

  assert_regmap_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en |-> (reg_rd_n && reg_wr_n && regmap_dis));

  assert_hold_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clear) && !$stable(buf_raddr)) |-> fetch_data == $past(buf_rdata));

  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clear) |-> (buf_raddr == '0 && fetch_data == '0));

  assert_oe_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_oe == (exec_en && !code_sel_n));
endmodule

bind exec_strobe_remap exec_remap_checker #(
  .DATA_W    (DATA_W),
  .BUF_DEPTH (BUF_DEPTH)
) u_chk (.*);

// File: tb/exec_strobe_remap_test.sv
`timescale 1ns/1ps
module exec_strobe_remap_test;
  localparam int DW    = 8;
  localparam int DEPTH = 2048;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          code_sel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic          exec_en = 1'b0, clear = 1'b0;
  logic [DW-1:0] buf_rdata;
  logic          flash_ce_n, fetch_oe, reg_rd_n, reg_wr_n, regmap_dis;
  logic [AW-1:0] buf_raddr;
  logic [DW-1:0] fetch_data;

  logic [DW-1:0] mem [DEPTH];
  int            checks = 0, errors = 0;
  int            exp_addr = 0;
  logic [DW-1:0] exp_hold = '0;
  bit            done = 0;
  int unsigned   seed_sink;

  always #4 clk = ~clk;

  assign buf_rdata = mem[buf_raddr];

  exec_strobe_remap uut (
    .clk(clk), .rst_n(rst_n), .code_sel_n(code_sel_n), .rd_n(rd_n), .wr_n(wr_n),
    .exec_en(exec_en), .clear(clear), .buf_rdata(buf_rdata),
    .flash_ce_n(flash_ce_n), .buf_raddr(buf_raddr), .fetch_data(fetch_data),
    .fetch_oe(fetch_oe), .reg_rd_n(reg_rd_n), .reg_wr_n(reg_wr_n),
    .regmap_dis(regmap_dis)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int next_addr(input int a);
    return (a == DEPTH - 1) ? 0 : a + 1;
  endfunction

  task automatic do_clear();
    @(negedge clk) clear = 1'b1;
    @(negedge clk) clear = 1'b0;
    exp_addr = 0;
    exp_hold = '0;
    check("R8 addr", int'(buf_raddr), 0);
    check("R8 data", int'(fetch_data), 0);
  endtask

  // Execute-mode fetch: byte must be the held one; afterwards the model steps
  task automatic exec_fetch();
    @(negedge clk) code_sel_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 fetch", int'(fetch_data), int'(exp_hold));
    check("R10 oe", int'(fetch_oe), 1);
    check("R4 ce", int'(flash_ce_n), 1);
    code_sel_n = 1'b1;
    repeat (5) @(negedge clk);
    exp_hold = mem[exp_addr];
    exp_addr = next_addr(exp_addr);
    check("R5 addr", int'(buf_raddr), exp_addr);
  endtask

  task automatic normal_fetch();
    @(negedge clk) code_sel_n = 1'b0;
    #1 check("R1 ce low", int'(flash_ce_n), 0);
    check("R10 oe normal", int'(fetch_oe), 0);
    @(negedge clk) code_sel_n = 1'b1;
    #1 check("R1 ce high", int'(flash_ce_n), 1);
    repeat (5) @(negedge clk);
    check("R5 no step normal", int'(buf_raddr), exp_addr);
  endtask

  task automatic data_write();
    @(negedge clk) wr_n = 1'b0;
    #1;
    if (exec_en) begin
      check("R3 ce on write", int'(flash_ce_n), 0);
      check("R6 wr blocked", int'(reg_wr_n), 1);
      check("R6 dis", int'(regmap_dis), 1);
    end else begin
      check("R2 no ce", int'(flash_ce_n), 1);
      check("R6 wr fwd", int'(reg_wr_n), 0);
      check("R6 dis low", int'(regmap_dis), 0);
    end
    @(negedge clk) wr_n = 1'b1;
  endtask

  task automatic data_read();
    @(negedge clk) rd_n = 1'b0;
    #1 check("R6 rd", int'(reg_rd_n), exec_en ? 1 : 0);
    check("R2 rd no ce", int'(flash_ce_n), 1);
    @(negedge clk) rd_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    seed_sink = $urandom(32'h5eed_1234);
    for (int i = 0; i < DEPTH; i++) mem[i] = DW'($urandom);
    repeat (3) @(negedge clk);
    check("R8 reset addr", int'(buf_raddr), 0);
    check("R8 reset data", int'(fetch_data), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Normal mode: passthrough, writes never select flash
    normal_fetch();
    data_write();
    data_read();

    // Execute mode: first fetch after clear is zero, then buffer order
    exec_en = 1'b1;
    do_clear();
    for (int i = 0; i < 6; i++) exec_fetch();
    data_write();
    data_read();

    // Round trip to normal mode must not disturb the stream (R5)
    exec_en = 1'b0;
    normal_fetch();
    exec_en = 1'b1;
    exec_fetch();

    // Full sweep past the last location: R9 wrap
    do_clear();
    for (int i = 0; i < DEPTH + 3; i++) exec_fetch();
    check("R9 wrapped addr", int'(buf_raddr), 3);

    // Random mix of modes, writes, reads and fetches
    for (int i = 0; i < 300; i++) begin
      case ($urandom_range(0, 4))
        0: begin exec_en = ~exec_en; @(negedge clk); end
        1: data_write();
        2: data_read();
        3: if (exec_en) exec_fetch(); else normal_fetch();
        default: if ($urandom_range(0, 3) == 0) do_clear(); else data_write();
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule